// File: doc/BRIEF.md
# Lockable SMM Memory Access Decoder

This block holds the configuration for protected system-management memory and routes every incoming memory request either to DRAM or to the downstream I/O port. A small byte-wide configuration port exposes a control register and a top-of-segment register. Requests arrive on a valid/ready port with an address, an SMM attribute flag and a flag saying whether the processor issued them. After one registered cycle the block presents a routing decision and an output address on a valid/ready response port.

Three windows are decoded. The first is a fixed high alias window that is folded onto the legacy 128 KB area. The second is a size-coded protected segment sitting just below a programmable top address. The third is the legacy 128 KB area itself. Once a lock bit is set, the enable and size fields freeze until reset.

Top module: `smm_route_dec`

## Requirements
- R1: After reset, both configuration registers read 00h, and no response is valid.
- R2: The control register at byte offset 62h has these fields: bit 0 is the global enable, bit 1 the high-alias enable, bit 2 the segment enable, bits 5:4 the segment size code, and bit 7 the lock. Bits 3 and 6 always read 0. Any offset other than 62h and 63h reads 00h.
- R3: The top-of-segment register at offset 63h is 8 bits wide and reads back as written. Its value times 512 KB is the segment top address.
- R4: When the global and high-alias enables are both 1, a request in FEDA_0000h..FEDB_FFFFh goes to DRAM with address 000A_0000h plus its offset from FEDA_0000h. Otherwise, such an address is an ordinary request and goes to DRAM unchanged.
- R5: A request in 000A_0000h..000B_FFFFh that hits no other window goes to DRAM only when the global enable is 1 and the SMM flag is set. In every other case it goes to the I/O port.
- R6: The segment is active when the global and segment enables are both 1. It covers the range from top minus size up to top minus 1, starting at 0 when the top is below the size. Size codes are 00 = 512 KB, 01 = 1 MB, 10 = 2 MB and 11 = 4 MB. Inside an active segment, only requests from the processor that carry the SMM flag go to DRAM; all others go to the I/O port. Addresses outside every window go to DRAM with the address unchanged.
- R7: The alias window takes priority over the segment, and the segment takes priority over the legacy area.
- R8: Writing 1 to the lock bit sets it. The same write still updates the other fields. The lock clears only on reset. While the lock is set, writes leave the enables and the size unchanged, and the top register stays writable.
- R9: reqReady is high when no response is pending or rspReady is high. An accepted request produces its response one cycle later. A response stays stable while rspReady is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 8 | Configuration byte offset |
| cfgWrData | input | 8 | Configuration write data |
| cfgRdData | output | 8 | Configuration read data for cfgAddr |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request accepted when high with reqValid |
| reqAddr | input | ADDR_W | Request address |
| reqSmm | input | 1 | Request carries the SMM attribute |
| reqFromCpu | input | 1 | Request issued by the processor |
| rspValid | output | 1 | Routing decision valid |
| rspReady | input | 1 | Consumer takes the decision |
| rspToDram | output | 1 | 1 = route to DRAM, 0 = forward to I/O port |
| rspAddr | output | ADDR_W | Address to use (remapped for alias hits) |

## Verification
The bench builds the block with its defaults: a 32-bit address and an 8-bit top register. With these values the alias window sits near 4 GB, and low top values put the segment over the legacy area, so the segment-over-legacy ordering can be reached. A top of 512 KB with the 4 MB size makes the window start clamp at address 0. Back-pressure on the response port is exercised while a second request waits, and the lock is tested last against writes that try to clear it or change the fields.

// File: rtl/smm_route_pkg.sv
package smm_route_pkg;
  localparam int CFG_DW = 8;
  localparam logic [7:0] CTRL_OFS = 8'h62;
  localparam logic [7:0] TOP_OFS = 8'h63;
  localparam int SEG_GRAN_LG = 19;          // 512 KB granule
  localparam int LEG_SPAN_LG = 17;          // 128 KB legacy area

  typedef struct packed {
    logic       locked;
    logic [1:0] segSize;
    logic       segEn;
    logic       highEn;
    logic       globalEn;
  } ctrl_t;

  typedef struct packed {
    logic load;     // request accepted this cycle
    logic drain;    // response consumed this cycle
  } strobe_t;
endpackage

// File: rtl/smm_route_ctrl.sv
module smm_route_ctrl
  import smm_route_pkg::*;
#(
  parameter int TOP_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic [7:0]           cfgAddr,
  input  logic [CFG_DW-1:0]    cfgWrData,
  output logic [CFG_DW-1:0]    cfgRdData,
  input  logic                 reqValid,
  output logic                 reqReady,
  output logic                 rspValid,
  input  logic                 rspReady,
  output ctrl_t                ctrlQ,
  output logic [TOP_W-1:0]     topQ,
  output strobe_t              stb
);
  logic ctrlWr, topWr;

  assign ctrlWr    = cfgWrEn && (cfgAddr == CTRL_OFS);
  assign topWr     = cfgWrEn && (cfgAddr == TOP_OFS);
  assign reqReady  = !rspValid || rspReady;
  assign stb.load  = reqValid && reqReady;
  assign stb.drain = rspValid && rspReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ    <= '0;
      topQ     <= '0;
      rspValid <= 1'b0;
    end else begin
      if (ctrlWr) begin
        if (!ctrlQ.locked) begin
          ctrlQ.globalEn <= cfgWrData[0];
          ctrlQ.highEn   <= cfgWrData[1];
          ctrlQ.segEn    <= cfgWrData[2];
          ctrlQ.segSize  <= cfgWrData[5:4];
        end
        ctrlQ.locked <= ctrlQ.locked | cfgWrData[7];
      end
      if (topWr) topQ <= cfgWrData[TOP_W-1:0];
      if (stb.load)       rspValid <= 1'b1;
      else if (stb.drain) rspValid <= 1'b0;
    end
  end

  always_comb begin
    cfgRdData = '0;
    if (cfgAddr == CTRL_OFS)
      cfgRdData = {ctrlQ.locked, 1'b0, ctrlQ.segSize, 1'b0,
                   ctrlQ.segEn, ctrlQ.highEn, ctrlQ.globalEn};
    else if (cfgAddr == TOP_OFS)
      cfgRdData = CFG_DW'(topQ);
  end
endmodule

// File: rtl/smm_route_dp.sv
module smm_route_dp
  import smm_route_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TOP_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  ctrl_t             ctrlQ,
  input  logic [TOP_W-1:0]  topQ,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqSmm,
  input  logic              reqFromCpu,
  output logic              rspToDram,
  output logic [ADDR_W-1:0] rspAddr
);
  localparam logic [ADDR_W-1:0] ALIAS_LO = ADDR_W'(32'hFEDA_0000);
  localparam logic [ADDR_W-1:0] ALIAS_HI = ADDR_W'(32'hFEDB_FFFF);
  localparam logic [ADDR_W-1:0] LEG_LO   = ADDR_W'(32'h000A_0000);
  localparam logic [ADDR_W-1:0] LEG_HI   = ADDR_W'(32'h000B_FFFF);
  localparam logic [ADDR_W-1:0] LEG_MASK = (ADDR_W'(1) << LEG_SPAN_LG) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] GRANULE  = ADDR_W'(1) << SEG_GRAN_LG;

  logic [ADDR_W-1:0] topAddr, segBytes, segBase, nextAddr;
  logic inAlias, inLeg, inSeg, aliasHit, segHit, nextDram;

  assign topAddr  = ADDR_W'(topQ) << SEG_GRAN_LG;
  assign segBytes = GRANULE << ctrlQ.segSize;
  assign segBase  = (topAddr >= segBytes) ? (topAddr - segBytes) : '0;

  assign inAlias  = (reqAddr >= ALIAS_LO) && (reqAddr <= ALIAS_HI);
  assign inLeg    = (reqAddr >= LEG_LO) && (reqAddr <= LEG_HI);
  assign inSeg    = (reqAddr >= segBase) && (reqAddr < topAddr);
  assign aliasHit = ctrlQ.globalEn && ctrlQ.highEn && inAlias;
  assign segHit   = ctrlQ.globalEn && ctrlQ.segEn && inSeg;

  always_comb begin
    nextAddr = reqAddr;
    nextDram = 1'b1;
    if (aliasHit) begin
      nextAddr = LEG_LO | (reqAddr & LEG_MASK);
    end else if (segHit) begin
      nextDram = reqFromCpu && reqSmm;
    end else if (inLeg) begin
      nextDram = ctrlQ.globalEn && reqSmm;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspToDram <= 1'b0;
      rspAddr   <= '0;
    end else if (stb.load) begin
      rspToDram <= nextDram;
      rspAddr   <= nextAddr;
    end
  end
endmodule

// File: rtl/smm_route_dec.sv
module smm_route_dec
  import smm_route_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TOP_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [7:0]        cfgAddr,
  input  logic [7:0]        cfgWrData,
  output logic [7:0]        cfgRdData,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqSmm,
  input  logic              reqFromCpu,
  output logic              rspValid,
  input  logic              rspReady,
  output logic              rspToDram,
  output logic [ADDR_W-1:0] rspAddr
);
  ctrl_t            ctrlQ;
  logic [TOP_W-1:0] topQ;
  strobe_t          stb;

  smm_route_ctrl #(.TOP_W(TOP_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .reqValid(reqValid),
    .reqReady(reqReady), .rspValid(rspValid), .rspReady(rspReady),
    .ctrlQ(ctrlQ), .topQ(topQ), .stb(stb)
  );

  smm_route_dp #(.ADDR_W(ADDR_W), .TOP_W(TOP_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .ctrlQ(ctrlQ), .topQ(topQ),
    .reqAddr(reqAddr), .reqSmm(reqSmm), .reqFromCpu(reqFromCpu),
    .rspToDram(rspToDram), .rspAddr(rspAddr)
  );
endmodule

// File: rtl/smm_route_chk.sv
module smm_route_chk
  import smm_route_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              rspValid,
  input logic              rspReady,
  input logic              rspToDram,
  input logic [ADDR_W-1:0] rspAddr,
  input ctrl_t             ctrlQ
);
  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(32'hFEDA_0000);
  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(32'hFEDB_FFFF);

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid && $stable(rspAddr) && $stable(rspToDram));

  // R9
  accept_to_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> rspValid);

  // R8
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlQ.locked |=> ctrlQ.locked);

  // R8
  locked_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlQ.locked |=> $stable({ctrlQ.globalEn, ctrlQ.highEn, ctrlQ.segEn, ctrlQ.segSize}));

  // R4
  alias_remap_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && ctrlQ.globalEn && ctrlQ.highEn &&
    (reqAddr >= A_LO) && (reqAddr <= A_HI)
    |=> rspToDram && (rspAddr == (ADDR_W'(32'h000A_0000) | ($past(reqAddr) & ADDR_W'(32'h1_FFFF)))));
endmodule

bind smm_route_dec smm_route_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqAddr(reqAddr), .rspValid(rspValid), .rspReady(rspReady),
  .rspToDram(rspToDram), .rspAddr(rspAddr), .ctrlQ(ctrlQ)
);

// File: tb/tb_smm_route_dec.sv
module tb_smm_route_dec;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [7:0] cfgAddr = 8'h00;
  logic [7:0] cfgWrData = 8'h00;
  logic [7:0] cfgRdData;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [31:0] reqAddr = '0;
  logic reqSmm = 1'b0;
  logic reqFromCpu = 1'b0;
  logic rspValid;
  logic rspReady = 1'b1;
  logic rspToDram;
  logic [31:0] rspAddr;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";
  bit finished = 0;

  // reference model state
  bit mGlob = 0, mHigh = 0, mSegEn = 0, mLock = 0;
  int mSize = 0, mTop = 0;
  bit mRspV = 0, mRspD = 0;
  longint unsigned mRspA = 0;

  always #5 clk = ~clk;

  smm_route_dec dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .reqValid(reqValid),
    .reqReady(reqReady), .reqAddr(reqAddr), .reqSmm(reqSmm),
    .reqFromCpu(reqFromCpu), .rspValid(rspValid), .rspReady(rspReady),
    .rspToDram(rspToDram), .rspAddr(rspAddr)
  );

  function automatic void route(longint unsigned a, bit smm, bit cpu,
                                output bit d, output longint unsigned oa);
    longint unsigned top, sz, base;
    top  = longint'(mTop) * 524288;
    sz   = 524288 * (64'd1 << mSize);
    base = (top >= sz) ? top - sz : 0;
    oa = a;
    d  = 1;
    if (mGlob && mHigh && a >= 64'hFEDA0000 && a <= 64'hFEDBFFFF) begin
      oa = 64'hA0000 + (a - 64'hFEDA0000);
    end else if (mGlob && mSegEn && a >= base && a < top) begin
      d = cpu && smm;
    end else if (a >= 64'hA0000 && a <= 64'hBFFFF) begin
      d = mGlob && smm;
    end
  endfunction

  function automatic int modelRead(logic [7:0] ofs);
    if (ofs == 8'h62) return (int'(mLock) << 7) | (mSize << 4) |
                             (int'(mSegEn) << 2) | (int'(mHigh) << 1) | int'(mGlob);
    if (ofs == 8'h63) return mTop;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mGlob = 0; mHigh = 0; mSegEn = 0; mLock = 0; mSize = 0; mTop = 0;
      mRspV = 0; mRspD = 0; mRspA = 0;
    end else begin
      if (reqValid && (!mRspV || rspReady)) begin
        route(longint'(reqAddr), reqSmm, reqFromCpu, mRspD, mRspA);
        mRspV = 1;
      end else if (rspReady) begin
        mRspV = 0;
      end
      if (cfgWrEn && cfgAddr == 8'h62) begin
        if (!mLock) begin
          mGlob = cfgWrData[0]; mHigh = cfgWrData[1]; mSegEn = cfgWrData[2];
          mSize = int'(cfgWrData[5:4]);
        end
        if (cfgWrData[7]) mLock = 1;
      end
      if (cfgWrEn && cfgAddr == 8'h63) mTop = int'(cfgWrData);
    end
  end

  task automatic check(string req, longint unsigned got, longint unsigned exp, string what);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      check(curReq, longint'(rspValid), longint'(mRspV), "rspValid");
      check(curReq, longint'(reqReady), longint'(!mRspV || rspReady), "reqReady");
      check(curReq, longint'(cfgRdData), longint'(modelRead(cfgAddr)), "cfgRdData");
      if (mRspV) begin
        check(curReq, longint'(rspToDram), longint'(mRspD), "rspToDram");
        check(curReq, longint'(rspAddr), mRspA, "rspAddr");
      end
    end
  end

  task automatic cfgWrite(logic [7:0] ofs, logic [7:0] data);
    @(negedge clk); #1;
    cfgWrEn = 1; cfgAddr = ofs; cfgWrData = data;
    @(negedge clk); #1;
    cfgWrEn = 0;
  endtask

  task automatic readExpect(string req, logic [7:0] ofs, logic [7:0] exp);
    @(negedge clk); #1;
    cfgAddr = ofs;
    #1;
    check(req, longint'(cfgRdData), longint'(exp), "read");
  endtask

  task automatic sendReq(logic [31:0] a, bit smm, bit cpu);
    @(negedge clk); #1;
    reqValid = 1; reqAddr = a; reqSmm = smm; reqFromCpu = cpu;
    @(negedge clk); #1;
    reqValid = 0;
  endtask

  task automatic routeExpect(string req, logic [31:0] a, bit smm, bit cpu,
                             bit expD, logic [31:0] expA);
    sendReq(a, smm, cpu);
    check(req, longint'(rspValid), 1, "rspValid");
    check(req, longint'(rspToDram), longint'(expD), "rspToDram");
    check(req, longint'(rspAddr), longint'(expA), "rspAddr");
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rstN = 1;

    // R1 reset state
    curReq = "R1";
    readExpect("R1", 8'h62, 8'h00);
    readExpect("R1", 8'h63, 8'h00);
    check("R1", longint'(rspValid), 0, "rspValid after reset");

    // R2 control layout and reserved bits
    curReq = "R2";
    cfgWrite(8'h62, 8'h7F);
    readExpect("R2", 8'h62, 8'h37);
    cfgWrite(8'h62, 8'h00);
    readExpect("R2", 8'h62, 8'h00);
    readExpect("R2", 8'h61, 8'h00);

    // R3 top register
    curReq = "R3";
    cfgWrite(8'h63, 8'hA5);
    readExpect("R3", 8'h63, 8'hA5);
    cfgWrite(8'h63, 8'h00);

    // R4 high alias remap
    curReq = "R4";
    cfgWrite(8'h62, 8'h03);
    routeExpect("R4", 32'hFEDA_1234, 1, 1, 1, 32'h000A_1234);
    routeExpect("R4", 32'hFEDB_FFFF, 0, 0, 1, 32'h000B_FFFF);
    routeExpect("R4", 32'hFEDC_0000, 1, 1, 1, 32'hFEDC_0000);
    cfgWrite(8'h62, 8'h02);
    routeExpect("R4", 32'hFEDA_1234, 1, 1, 1, 32'hFEDA_1234);

    // R5 legacy area
    curReq = "R5";
    cfgWrite(8'h62, 8'h00);
    routeExpect("R5", 32'h000A_5000, 1, 1, 0, 32'h000A_5000);
    cfgWrite(8'h62, 8'h01);
    routeExpect("R5", 32'h000A_5000, 1, 0, 1, 32'h000A_5000);
    routeExpect("R5", 32'h000B_0000, 0, 1, 0, 32'h000B_0000);

    // R6 segment window, size codes and access filter
    curReq = "R6";
    cfgWrite(8'h63, 8'h10);                 // top = 8 MB
    cfgWrite(8'h62, 8'h05);                 // size 512 KB
    routeExpect("R6", 32'h0078_0000, 1, 1, 1, 32'h0078_0000);
    routeExpect("R6", 32'h0078_0000, 0, 1, 0, 32'h0078_0000);
    routeExpect("R6", 32'h007F_FFFF, 1, 0, 0, 32'h007F_FFFF);
    routeExpect("R6", 32'h0077_FFFF, 0, 0, 1, 32'h0077_FFFF);
    routeExpect("R6", 32'h0080_0000, 0, 0, 1, 32'h0080_0000);
    cfgWrite(8'h62, 8'h35);                 // size 4 MB
    routeExpect("R6", 32'h0040_0000, 0, 1, 0, 32'h0040_0000);
    routeExpect("R6", 32'h003F_FFFF, 0, 1, 1, 32'h003F_FFFF);
    cfgWrite(8'h62, 8'h25);                 // size 2 MB
    routeExpect("R6", 32'h005F_FFFF, 0, 1, 1, 32'h005F_FFFF);
    routeExpect("R6", 32'h0060_0000, 0, 1, 0, 32'h0060_0000);
    cfgWrite(8'h62, 8'h31);                 // segment enable off
    routeExpect("R6", 32'h0040_0000, 0, 1, 1, 32'h0040_0000);
    cfgWrite(8'h62, 8'h34);                 // global enable off
    routeExpect("R6", 32'h0040_0000, 0, 1, 1, 32'h0040_0000);
    cfgWrite(8'h63, 8'h01);                 // top below size: starts at 0
    cfgWrite(8'h62, 8'h35);
    routeExpect("R6", 32'h0000_1000, 0, 0, 0, 32'h0000_1000);

    // R7 segment over legacy
    curReq = "R7";
    cfgWrite(8'h63, 8'h02);                 // top = 1 MB
    cfgWrite(8'h62, 8'h05);                 // window 80000h..FFFFFh
    routeExpect("R7", 32'h000A_5000, 1, 0, 0, 32'h000A_5000);
    routeExpect("R7", 32'h000A_5000, 1, 1, 1, 32'h000A_5000);

    // R9 back-pressure
    curReq = "R9";
    cfgWrite(8'h62, 8'h00);
    @(negedge clk); #1;
    rspReady = 0;
    reqValid = 1; reqAddr = 32'h0000_1000; reqSmm = 0; reqFromCpu = 0;
    @(negedge clk); #1;
    check("R9", longint'(rspValid), 1, "rspValid one cycle after accept");
    check("R9", longint'(reqReady), 0, "reqReady while stalled");
    reqAddr = 32'h000A_5000;
    @(negedge clk); @(negedge clk); #1;
    check("R9", longint'(rspAddr), 64'h1000, "held rspAddr");
    check("R9", longint'(rspToDram), 1, "held rspToDram");
    rspReady = 1;
    @(negedge clk); #1;
    reqValid = 0;
    check("R9", longint'(rspAddr), 64'hA5000, "next response after release");
    check("R9", longint'(rspToDram), 0, "next response route");
    @(negedge clk); #1;
    check("R9", longint'(rspValid), 0, "response drained");

    // R8 lock
    curReq = "R8";
    cfgWrite(8'h62, 8'h81);
    readExpect("R8", 8'h62, 8'h81);
    cfgWrite(8'h62, 8'h36);
    readExpect("R8", 8'h62, 8'h81);
    cfgWrite(8'h62, 8'h00);
    readExpect("R8", 8'h62, 8'h81);
    cfgWrite(8'h63, 8'h20);
    readExpect("R8", 8'h63, 8'h20);
    routeExpect("R8", 32'h000A_5000, 1, 0, 1, 32'h000A_5000);

    repeat (2) @(negedge clk);
    #1 finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule